// File: doc/BRIEF.md
# Per-Hart Interrupt Delivery Selector

This block decides, for every hart in a wired-delivery interrupt domain, which pending source should be presented to it and whether the hart's external interrupt line is raised. Each source carries a routing entry that names a destination hart (a 14-bit index) and a priority. Each hart has three settings: a delivery-enable bit, a force bit and a priority threshold. A source competes for a hart only if it is pending and enabled, its routing entry names that hart, and it passes the threshold. The winner is the most urgent source, which is the one with the smallest priority number.

The winner of every hart is computed combinationally over all sources and then registered once. The registered value is presented as a per-hart top word and also drives the interrupt line. A claim request from a hart returns that hart's top word on the following cycle. If a source won, the block also pulses a clear strobe carrying the source number, so that the source gateway can drop the pending bit or re-arm a level source. If nothing won, the claim clears the hart's force bit instead.

Top module: `hart_irq_select`

## Requirements
- R1: A source is considered for hart h only if its pending input and enable input are both 1 and the full 14-bit hart field of its routing entry equals h. A hart index with no matching hart routes the source to nobody.
- R2: With a hart threshold of 0 no source is excluded. With a nonzero threshold T, every source whose priority is T or greater is excluded.
- R3: Among the eligible sources the smallest priority number wins. On equal priority the lower source number wins.
- R4: The top word of a hart holds the winning source number in bits 25:16 and its priority in bits 7:0, with all other bits 0. It is all zero when no source qualifies. It reflects the inputs one clock edge after they are applied.
- R5: A hart's interrupt line is 1 exactly when the domain enable input is 1, the hart's delivery bit is 1, and either its force bit is 1 or its top word is nonzero. The line is registered.
- R6: A claim from hart h whose top word is nonzero returns that top word on claim_word one cycle later. In the same cycle it pulses clr_valid for one cycle with clr_src set to the winning source.
- R7: A claim from hart h whose top word is zero returns zero, produces no clear pulse, and clears h's force bit.
- R8: A routing write (tgt_wdata) takes the hart index from bits 31:18 and the priority from bits PRIO_W-1:0. A written priority of 0 is stored as 1. At reset every source routes to hart 0 with priority 1.
- R9: A setting write (cfg_field 0 = delivery, 1 = force, 2 = threshold) keeps only bit 0 of the data for delivery and force, and keeps only the low PRIO_W bits for the threshold. The value 3 is ignored.
- R10: While reset is active and immediately after it, all top words, interrupt lines, claim_word and clr_valid are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| domain_ie | input | 1 | Domain-wide interrupt enable |
| src_pend_i | input | NSRC | Pending bit of sources NSRC..1 |
| src_en_i | input | NSRC | Enable bit of sources NSRC..1 |
| tgt_we | input | 1 | Routing entry write strobe |
| tgt_src | input | SRC_W | Source whose routing entry is written |
| tgt_wdata | input | 32 | Routing data: hart 31:18, priority PRIO_W-1:0 |
| cfg_we | input | 1 | Hart setting write strobe |
| cfg_hart | input | HIDX_W | Hart whose setting is written |
| cfg_field | input | 2 | 0 delivery, 1 force, 2 threshold |
| cfg_wdata | input | 32 | Setting data |
| claim_req | input | 1 | Claim strobe |
| claim_hart | input | HIDX_W | Claiming hart |
| claim_word | output | 32 | Top word returned by the claim of the previous cycle |
| clr_valid | output | 1 | Gateway clear / re-arm strobe |
| clr_src | output | SRC_W | Source to clear or re-arm |
| top_word | output | NHART*32 | Registered top word of every hart, hart h at bits h*32+31:h*32 |
| irq_o | output | NHART | External interrupt line of every hart |

## Verification
The hardest situation to reach is a close contest: several eligible sources aimed at the same hart with equal priorities, while a threshold sits exactly at one of those priorities. The bench reaches it with a sweep. Every pending pattern of a seven-source configuration is crossed with every threshold value, and the routing table is set so that priorities repeat and two harts share the sources. Empty claims under force, and routing to a nonexistent hart, are each set up with dedicated sequences.

// File: rtl/hart_irq_select.sv
module hart_irq_select #(
  parameter int NSRC   = 31,
  parameter int NHART  = 4,
  parameter int PRIO_W = 3,
  localparam int SRC_W  = $clog2(NSRC + 1),
  localparam int HIDX_W = (NHART > 1) ? $clog2(NHART) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  domain_ie,
  input  logic [NSRC:1]         src_pend_i,
  input  logic [NSRC:1]         src_en_i,
  input  logic                  tgt_we,
  input  logic [SRC_W-1:0]      tgt_src,
  input  logic [31:0]           tgt_wdata,
  input  logic                  cfg_we,
  input  logic [HIDX_W-1:0]     cfg_hart,
  input  logic [1:0]            cfg_field,
  input  logic [31:0]           cfg_wdata,
  input  logic                  claim_req,
  input  logic [HIDX_W-1:0]     claim_hart,
  output logic [31:0]           claim_word,
  output logic                  clr_valid,
  output logic [SRC_W-1:0]      clr_src,
  output logic [NHART*32-1:0]   top_word,
  output logic [NHART-1:0]      irq_o
);
  localparam int HART_W = 14;

  logic [HART_W-1:0] tgt_hart [1:NSRC];
  logic [PRIO_W-1:0] tgt_prio [1:NSRC];
  logic [NHART-1:0]  dlv_q, force_q;
  logic [PRIO_W-1:0] thr_q [NHART];
  logic [31:0]       top_n [NHART];
  logic [31:0]       top_q [NHART];
  logic [31:0]       sel_top;

  wire tgt_ok   = tgt_we && (int'(tgt_src) >= 1) && (int'(tgt_src) <= NSRC);
  wire cfg_ok   = cfg_we && (int'(cfg_hart) < NHART);
  wire claim_ok = claim_req && (int'(claim_hart) < NHART);
  wire [PRIO_W-1:0] wr_prio = tgt_wdata[PRIO_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 1; s <= NSRC; s++) begin
        tgt_hart[s] <= '0;
        tgt_prio[s] <= PRIO_W'(1);
      end
    end else if (tgt_ok) begin
      tgt_hart[tgt_src] <= tgt_wdata[31:18];
      tgt_prio[tgt_src] <= (wr_prio == '0) ? PRIO_W'(1) : wr_prio;
    end
  end

  always_comb begin
    sel_top = '0;
    for (int h = 0; h < NHART; h++)
      if (int'(claim_hart) == h) sel_top = top_q[h];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_q   <= '0;
      force_q <= '0;
      for (int h = 0; h < NHART; h++) thr_q[h] <= '0;
    end else begin
      if (claim_ok && sel_top == '0) force_q[claim_hart] <= 1'b0;
      if (cfg_ok) begin
        case (cfg_field)
          2'd0:    dlv_q[cfg_hart]   <= cfg_wdata[0];
          2'd1:    force_q[cfg_hart] <= cfg_wdata[0];
          2'd2:    thr_q[cfg_hart]   <= cfg_wdata[PRIO_W-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar h = 0; h < NHART; h++) begin : g_hart
    logic              found;
    logic [SRC_W-1:0]  b_src;
    logic [PRIO_W-1:0] b_pr;

    always_comb begin
      found = 1'b0;
      b_src = '0;
      b_pr  = '0;
      for (int s = 1; s <= NSRC; s++) begin
        if (src_pend_i[s] && src_en_i[s] && tgt_hart[s] == HART_W'(h) &&
            (thr_q[h] == '0 || tgt_prio[s] < thr_q[h]) &&
            (!found || tgt_prio[s] < b_pr)) begin
          found = 1'b1;
          b_src = SRC_W'(s);
          b_pr  = tgt_prio[s];
        end
      end
    end

    assign top_n[h] = found ? ((32'(b_src) << 16) | 32'(b_pr)) : 32'd0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        top_q[h] <= '0;
        irq_o[h] <= 1'b0;
      end else begin
        top_q[h] <= top_n[h];
        irq_o[h] <= domain_ie && dlv_q[h] && (force_q[h] || top_n[h] != '0);
      end
    end

    assign top_word[h*32 +: 32] = top_q[h];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_word <= '0;
      clr_valid  <= 1'b0;
      clr_src    <= '0;
    end else begin
      claim_word <= claim_ok ? sel_top : '0;
      clr_valid  <= claim_ok && sel_top != '0;
      clr_src    <= claim_ok ? sel_top[16 +: SRC_W] : '0;
    end
  end
endmodule

module hart_irq_select_chk #(
  parameter int NSRC   = 31,
  parameter int NHART  = 4,
  parameter int PRIO_W = 3,
  localparam int SRC_W  = $clog2(NSRC + 1),
  localparam int HIDX_W = (NHART > 1) ? $clog2(NHART) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                domain_ie,
  input logic                cfg_we,
  input logic [HIDX_W-1:0]   cfg_hart,
  input logic [1:0]          cfg_field,
  input logic                claim_req,
  input logic [HIDX_W-1:0]   claim_hart,
  input logic                clr_valid,
  input logic [SRC_W-1:0]    clr_src,
  input logic [NHART*32-1:0] top_word,
  input logic [NHART-1:0]    irq_o,
  input logic [NHART-1:0]    force_q,
  input logic [NHART-1:0]    dlv_q
);
  assert_ie_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !domain_ie |=> irq_o == '0);

  assert_clr_src_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> (clr_src != '0 && int'(clr_src) <= NSRC));

  for (genvar h = 0; h < NHART; h++) begin : g_chk
    assert_force_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
      domain_ie && dlv_q[h] && force_q[h] |=> irq_o[h]);

    assert_empty_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
      claim_req && int'(claim_hart) == h && top_word[h*32 +: 32] == '0 &&
      !(cfg_we && cfg_field == 2'd1 && int'(cfg_hart) == h) |=> !force_q[h]);

    assert_prio_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      top_word[h*32 +: 32] != '0 |-> top_word[h*32 +: PRIO_W] != '0);
  end
endmodule

bind hart_irq_select hart_irq_select_chk #(.NSRC(NSRC), .NHART(NHART), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/hart_irq_select_bench.sv
module hart_irq_select_bench;
  localparam int NSRC = 7, NHART = 2, PRIO_W = 3, SRC_W = 3, HIDX_W = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, domain_ie, tgt_we, cfg_we, claim_req, clr_valid;
  logic [NSRC:1] src_pend_i, src_en_i;
  logic [SRC_W-1:0] tgt_src, clr_src;
  logic [31:0] tgt_wdata, cfg_wdata, claim_word;
  logic [HIDX_W-1:0] cfg_hart, claim_hart;
  logic [1:0] cfg_field;
  logic [NHART*32-1:0] top_word;
  logic [NHART-1:0] irq_o;

  hart_irq_select #(.NSRC(NSRC), .NHART(NHART), .PRIO_W(PRIO_W)) u_hart_irq_select (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [13:0] m_hart [1:NSRC];
  logic [PRIO_W-1:0] m_prio [1:NSRC];
  logic [PRIO_W-1:0] m_thr [NHART];

  function automatic logic [31:0] exp_top(int h);
    int bs = 0, bp = 0;
    for (int s = 1; s <= NSRC; s++)
      if (src_pend_i[s] && src_en_i[s] && int'(m_hart[s]) == h &&
          (m_thr[h] == 0 || m_prio[s] < m_thr[h]) && (bs == 0 || int'(m_prio[s]) < bp)) begin
        bs = s;
        bp = int'(m_prio[s]);
      end
    return (bs == 0) ? 32'd0 : 32'((bs << 16) | bp);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_tgt(int s, logic [31:0] d);
    @(negedge clk);
    tgt_we = 1'b1; tgt_src = SRC_W'(s); tgt_wdata = d;
    @(negedge clk);
    tgt_we = 1'b0;
    m_hart[s] = d[31:18];
    m_prio[s] = (d[PRIO_W-1:0] == 0) ? PRIO_W'(1) : d[PRIO_W-1:0];
  endtask

  task automatic wr_cfg(int h, int f, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_hart = HIDX_W'(h); cfg_field = 2'(f); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (f == 2) m_thr[h] = d[PRIO_W-1:0];
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic claim(int h);
    @(negedge clk);
    claim_req = 1'b1; claim_hart = HIDX_W'(h);
    @(negedge clk);
    claim_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; domain_ie = 1'b0; tgt_we = 1'b0; cfg_we = 1'b0; claim_req = 1'b0;
    src_pend_i = '0; src_en_i = '0; tgt_src = '0; tgt_wdata = '0; cfg_hart = '0;
    cfg_field = '0; cfg_wdata = '0; claim_hart = '0;
    for (int s = 1; s <= NSRC; s++) begin m_hart[s] = '0; m_prio[s] = 1; end
    for (int h = 0; h < NHART; h++) m_thr[h] = '0;
    repeat (3) @(negedge clk);
    chk("R10 top in reset", top_word[31:0] | top_word[63:32], 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 top after reset", top_word[31:0] | top_word[63:32], 0);
    chk("R10 irq after reset", 32'(irq_o), 0);
    chk("R10 claim_word", claim_word, 0);
    chk("R10 clr_valid", 32'(clr_valid), 0);

    // R8 reset routing: hart 0, priority 1
    src_pend_i = 7'b0000100; src_en_i = '1;
    settle();
    chk("R8 reset routing", top_word[31:0], (32'd3 << 16) | 32'd1);
    chk("R8 reset routing other hart", top_word[63:32], 0);

    for (int s = 1; s <= NSRC; s++)
      wr_tgt(s, (32'((s >> 1) & 1) << 18) | 32'(((s * 3) % 4) + 1));
    wr_cfg(0, 0, 1);
    wr_cfg(1, 0, 1);
    domain_ie = 1'b1;

    // R1 R2 R3 R4 R5 sweep
    for (int i = 0; i < 1024; i++) begin
      if (i % 128 == 0) begin
        wr_cfg(0, 2, 32'(i / 128));
        wr_cfg(1, 2, 32'(i / 128));
      end
      src_pend_i = 7'(i);
      src_en_i = ((i / 128) % 2 == 1) ? 7'h6d : 7'h7f;
      settle();
      for (int h = 0; h < NHART; h++) begin
        chk("R1/R2/R3/R4 top word", top_word[h*32 +: 32], exp_top(h));
        chk("R5 irq line", 32'(irq_o[h]), 32'(exp_top(h) != 0));
      end
    end
    wr_cfg(0, 2, 0);
    wr_cfg(1, 2, 0);

    // R1 route to a hart that does not exist
    wr_tgt(4, (32'd5 << 18) | 32'd1);
    src_pend_i = 7'b0001000; src_en_i = '1;
    settle();
    chk("R1 absent hart 0", top_word[31:0], 0);
    chk("R1 absent hart 1", top_word[63:32], 0);
    wr_tgt(4, 32'd1);
    settle();
    chk("R1 routed back", top_word[31:0], (32'd4 << 16) | 32'd1);

    // R8 priority masking and zero
    src_pend_i = 7'b0010000;
    wr_tgt(5, 32'h1A);
    settle();
    chk("R8 masked priority", top_word[31:0], (32'd5 << 16) | 32'd2);
    wr_tgt(5, 32'h08);
    settle();
    chk("R8 masked to zero stored 1", top_word[31:0], (32'd5 << 16) | 32'd1);
    wr_tgt(5, 32'h00);
    settle();
    chk("R8 zero stored 1", top_word[31:0], (32'd5 << 16) | 32'd1);

    // R9 threshold, delivery and force masking
    wr_cfg(0, 2, 32'h9);
    settle();
    chk("R9 threshold masked to 1", top_word[31:0], 0);
    wr_cfg(0, 2, 32'h8);
    settle();
    chk("R9 threshold masked to 0", top_word[31:0], (32'd5 << 16) | 32'd1);
    wr_cfg(0, 0, 32'h2);
    settle();
    chk("R9 delivery keeps bit 0", 32'(irq_o[0]), 0);
    chk("R5 top stays with delivery off", top_word[31:0], (32'd5 << 16) | 32'd1);
    wr_cfg(0, 0, 32'h3);
    settle();
    chk("R5 delivery on", 32'(irq_o[0]), 1);
    wr_cfg(1, 3, 32'h1);
    settle();
    chk("R9 field 3 ignored", 32'(irq_o[1]), 0);
    wr_cfg(1, 1, 32'h2);
    settle();
    chk("R9 force keeps bit 0", 32'(irq_o[1]), 0);
    wr_cfg(1, 1, 32'h1);
    settle();
    chk("R5 force raises line", 32'(irq_o[1]), 1);
    chk("R5 force top empty", top_word[63:32], 0);

    // R7 empty claim
    claim(1);
    chk("R7 empty claim word", claim_word, 0);
    chk("R7 no clear pulse", 32'(clr_valid), 0);
    settle();
    chk("R7 force cleared", 32'(irq_o[1]), 0);

    // R6 claim with a winner, tie between 4 and 5
    src_pend_i = 7'b0011000;
    settle();
    claim(0);
    chk("R6 claim word", claim_word, (32'd4 << 16) | 32'd1);
    chk("R6 clear pulse", 32'(clr_valid), 1);
    chk("R6 clear source", 32'(clr_src), 4);
    @(negedge clk);
    chk("R6 single pulse", 32'(clr_valid), 0);

    // R5 domain enable off
    domain_ie = 1'b0;
    settle();
    chk("R5 domain off", 32'(irq_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule